// File: doc/BRIEF.md
# Flash Operation Sequencer

This block is the controller-side state machine that converts a single host request into the bus cycles of an 8/16-bit NAND flash device. The host places an operation code and a 32-bit page or block address on its inputs and pulses `start`. The sequencer then works through the operation. It latches one or two opcode bytes with the command strobe and, where the operation needs it, two 16-bit address words with the address strobe. It waits out the device's busy pulse and moves page data between the 16-bit flash bus and a 32-bit word buffer. When the operation completes it raises a one-cycle interrupt and returns to idle.

Each bus cycle takes two clocks: one with the write or read strobe low and one with it high. The latch selects do not change across that pair. Page reads pack two 16-bit words into one buffer word, and page programs split each buffer word into two 16-bit writes. In both directions the lower half comes first. An identification read fills a 32-bit ID register and a status read fills an 8-bit status register. The page length in 32-bit words is the parameter `PAGE_WORDS`, which must be 2 or more.

Top module: `nand_op_sequencer`

## Requirements
- R1: After reset `host_busy` and `host_irq` are 0, all strobes and latch selects (`fl_cs_n`, `fl_cmd_lat_n`, `fl_adr_lat_n`, `fl_wr_n`, `fl_rd_n`) are 1, `fl_wprot_n` is 0 and `id_word` is 0.
- R2: `op_sel` selects the operation: 0 page read (opcodes 00h then 30h), 1 page program (80h then 10h), 2 block erase (60h then D0h), 3 read ID (90h), 4 read status (70h), 5 reset (FFh). Each opcode is latched by a write strobe while `fl_cmd_lat_n` is low.
- R3: Page read, page program and block erase send exactly two address words after the first opcode, `page_addr[15:0]` first and then `page_addr[31:16]`. Read ID, read status and reset send no address.
- R4: Every write or read strobe is low for exactly one clock and then high for at least one clock. `fl_cmd_lat_n` and `fl_adr_lat_n` hold the same value across each strobe. The two strobes are never low together, and `fl_cs_n` is low whenever a strobe is low.
- R5: For a page read, no read strobe is issued until `fl_ready` has fallen and then risen again after 30h.
- R6: A page read performs 2*PAGE_WORDS read cycles. For each pair it writes one buffer word at address k, with the first 16-bit value in bits 15:0 and the second in bits 31:16.
- R7: A page program performs 2*PAGE_WORDS data writes between 80h's address and 10h. For each buffer word k it sends bits 15:0 first and bits 31:16 second.
- R8: After page program, block erase and reset, `host_irq` is raised only after the device's busy pulse has ended.
- R9: Read ID stores the first value read in `id_word[15:0]` and the second in `id_word[31:16]`. Read status stores bits 7:0 of the single value read in `status_byte`.
- R10: On completion `host_irq` is high for exactly one clock while `host_busy` is still high, and `host_busy` is 0 on the next clock.
- R11: A `start` that arrives while `host_busy` is high is ignored. A `start` with `op_sel` 6 or 7 is ignored and leaves the block idle.
- R12: `fl_wprot_n` is 1 only while a page program or block erase is in progress, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin an operation |
| op_sel | input | 3 | Operation code sampled with `start` |
| page_addr | input | 32 | Page/block address sampled with `start` |
| host_busy | output | 1 | High from accepted start until idle |
| host_irq | output | 1 | One-cycle completion pulse |
| id_word | output | 32 | Last identification value |
| status_byte | output | 8 | Last device status byte |
| buf_addr | output | $clog2(PAGE_WORDS) | Word buffer address |
| buf_rdata | input | 32 | Word buffer read data (combinational read) |
| buf_we | output | 1 | Word buffer write enable |
| buf_wdata | output | 32 | Word buffer write data |
| fl_cs_n | output | 1 | Device select, active low |
| fl_cmd_lat_n | output | 1 | Command latch select, active low |
| fl_adr_lat_n | output | 1 | Address latch select, active low |
| fl_wr_n | output | 1 | Write strobe, active low |
| fl_rd_n | output | 1 | Read strobe, active low |
| fl_wprot_n | output | 1 | Write protect, active low |
| fl_dout | output | 16 | Bus value driven to the device |
| fl_din | input | 16 | Bus value returned by the device |
| fl_ready | input | 1 | Device ready (low while busy) |

## Verification
A wrong state register or phase bit appears at the device pins within one bus cycle, that is within two clocks. It shows as an extra or missing opcode or address word, a strobe held low for two clocks, or a latch select that changes under a strobe. A wrong half-word counter shows up later: swapped halves or shifted words in the buffer or in the data written to the device, visible once the operation's interrupt fires. A wrong wait state shows as a read strobe or an interrupt during the device's busy pulse. A wrong idle handling shows as a second command sequence after a start that should have been ignored.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

    localparam int ADDR_CYCLES = 2;

    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_PROG  = 3'd1,
        OP_ERASE = 3'd2,
        OP_ID    = 3'd3,
        OP_STAT  = 3'd4,
        OP_RESET = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        DK_NONE,
        DK_PAGE_OUT,
        DK_PAGE_IN,
        DK_ID,
        DK_STAT
    } dkind_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD1,
        ST_ADDR,
        ST_DIN,
        ST_CMD2,
        ST_WFALL,
        ST_WRISE,
        ST_DOUT,
        ST_DONE
    } st_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] opc1;
        logic       has_addr;
        logic       has_opc2;
        logic [7:0] opc2;
        logic       waits;
        dkind_e     kind;
    } opinfo_t;

endpackage

// File: rtl/nseq_decode.sv
module nseq_decode
    import nseq_pkg::*;
(
    input  logic [2:0] op_code,
    output opinfo_t    info
);

    always_comb begin
        info          = '0;
        info.kind     = DK_NONE;
        case (op_code)
            OP_READ: begin
                info.valid    = 1'b1;
                info.opc1     = 8'h00;
                info.has_addr = 1'b1;
                info.has_opc2 = 1'b1;
                info.opc2     = 8'h30;
                info.waits    = 1'b1;
                info.kind     = DK_PAGE_OUT;
            end
            OP_PROG: begin
                info.valid    = 1'b1;
                info.opc1     = 8'h80;
                info.has_addr = 1'b1;
                info.has_opc2 = 1'b1;
                info.opc2     = 8'h10;
                info.waits    = 1'b1;
                info.kind     = DK_PAGE_IN;
            end
            OP_ERASE: begin
                info.valid    = 1'b1;
                info.opc1     = 8'h60;
                info.has_addr = 1'b1;
                info.has_opc2 = 1'b1;
                info.opc2     = 8'hD0;
                info.waits    = 1'b1;
            end
            OP_ID: begin
                info.valid    = 1'b1;
                info.opc1     = 8'h90;
                info.kind     = DK_ID;
            end
            OP_STAT: begin
                info.valid    = 1'b1;
                info.opc1     = 8'h70;
                info.kind     = DK_STAT;
            end
            OP_RESET: begin
                info.valid    = 1'b1;
                info.opc1     = 8'hFF;
                info.waits    = 1'b1;
            end
            default: info.valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/nseq_pack.sv
module nseq_pack (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        capture,
    input  logic [15:0] din,
    input  logic [31:0] word,
    input  logic        sel_hi,
    output logic [31:0] packed_word,
    output logic [15:0] half
);

    logic [15:0] lo_d, lo_q;

    always_comb begin
        lo_d = lo_q;
        if (capture) lo_d = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lo_q <= '0;
        else        lo_q <= lo_d;
    end

    assign packed_word = {din, lo_q};
    assign half        = sel_hi ? word[31:16] : word[15:0];

endmodule

// File: rtl/nand_op_sequencer.sv
module nand_op_sequencer
    import nseq_pkg::*;
#(
    parameter int PAGE_WORDS = 8,
    localparam int CW = $clog2(2 * PAGE_WORDS),
    localparam int AW = $clog2(PAGE_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    op_sel,
    input  logic [31:0]   page_addr,
    output logic          host_busy,
    output logic          host_irq,
    output logic [31:0]   id_word,
    output logic [7:0]    status_byte,
    output logic [AW-1:0] buf_addr,
    input  logic [31:0]   buf_rdata,
    output logic          buf_we,
    output logic [31:0]   buf_wdata,
    output logic          fl_cs_n,
    output logic          fl_cmd_lat_n,
    output logic          fl_adr_lat_n,
    output logic          fl_wr_n,
    output logic          fl_rd_n,
    output logic          fl_wprot_n,
    output logic [15:0]   fl_dout,
    input  logic [15:0]   fl_din,
    input  logic          fl_ready
);

    localparam logic [CW-1:0] PAGE_LAST = CW'(2 * PAGE_WORDS - 1);
    localparam logic [CW-1:0] ADDR_LAST = CW'(ADDR_CYCLES - 1);

    typedef struct packed {
        st_e          st;
        logic         ph;
        logic [CW-1:0] cnt;
        logic [2:0]   op;
        logic [31:0]  addr;
        logic [31:0]  id;
        logic [7:0]   stat;
        logic         bwe;
        logic [31:0]  bwdata;
    } seq_t;

    seq_t          q, d;
    opinfo_t       info;
    logic [2:0]    dec_op;
    logic [CW-1:0] last;
    logic          cap_lo;
    logic [31:0]   packed_word;
    logic [15:0]   out_half;

    assign dec_op = (q.st == ST_IDLE) ? op_sel : q.op;

    nseq_decode i_decode (
        .op_code (dec_op),
        .info    (info)
    );

    nseq_pack i_pack (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (cap_lo),
        .din         (fl_din),
        .word        (buf_rdata),
        .sel_hi      (q.cnt[0]),
        .packed_word (packed_word),
        .half        (out_half)
    );

    always_comb begin
        case (info.kind)
            DK_PAGE_OUT, DK_PAGE_IN: last = PAGE_LAST;
            DK_ID:                   last = CW'(1);
            default:                 last = '0;
        endcase
    end

    always_comb begin
        d      = q;
        d.bwe  = 1'b0;
        cap_lo = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start && info.valid) begin
                    d.st   = ST_CMD1;
                    d.ph   = 1'b0;
                    d.cnt  = '0;
                    d.op   = op_sel;
                    d.addr = page_addr;
                end
            end
            ST_CMD1: begin
                if (!q.ph) begin
                    d.ph = 1'b1;
                end else begin
                    d.ph  = 1'b0;
                    d.cnt = '0;
                    if (info.has_addr)                                d.st = ST_ADDR;
                    else if (info.kind == DK_ID || info.kind == DK_STAT) d.st = ST_DOUT;
                    else if (info.waits)                              d.st = ST_WFALL;
                    else                                              d.st = ST_DONE;
                end
            end
            ST_ADDR: begin
                if (!q.ph) begin
                    d.ph = 1'b1;
                end else begin
                    d.ph = 1'b0;
                    if (q.cnt == ADDR_LAST) begin
                        d.cnt = '0;
                        if (info.kind == DK_PAGE_IN) d.st = ST_DIN;
                        else if (info.has_opc2)      d.st = ST_CMD2;
                        else if (info.waits)         d.st = ST_WFALL;
                        else                         d.st = ST_DONE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_DIN: begin
                if (!q.ph) begin
                    d.ph = 1'b1;
                end else begin
                    d.ph = 1'b0;
                    if (q.cnt == last) begin
                        d.cnt = '0;
                        if (info.has_opc2)   d.st = ST_CMD2;
                        else if (info.waits) d.st = ST_WFALL;
                        else                 d.st = ST_DONE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_CMD2: begin
                if (!q.ph) begin
                    d.ph = 1'b1;
                end else begin
                    d.ph  = 1'b0;
                    d.cnt = '0;
                    if (info.waits)                   d.st = ST_WFALL;
                    else if (info.kind == DK_PAGE_OUT) d.st = ST_DOUT;
                    else                              d.st = ST_DONE;
                end
            end
            ST_WFALL: begin
                if (!fl_ready) d.st = ST_WRISE;
            end
            ST_WRISE: begin
                if (fl_ready) begin
                    d.ph  = 1'b0;
                    d.cnt = '0;
                    d.st  = (info.kind == DK_PAGE_OUT) ? ST_DOUT : ST_DONE;
                end
            end
            ST_DOUT: begin
                if (!q.ph) begin
                    d.ph = 1'b1;
                    case (info.kind)
                        DK_PAGE_OUT: begin
                            if (!q.cnt[0]) begin
                                cap_lo = 1'b1;
                            end else begin
                                d.bwe    = 1'b1;
                                d.bwdata = packed_word;
                            end
                        end
                        DK_ID: begin
                            if (!q.cnt[0]) cap_lo = 1'b1;
                            else           d.id   = packed_word;
                        end
                        DK_STAT: d.stat = fl_din[7:0];
                        default: ;
                    endcase
                end else begin
                    d.ph = 1'b0;
                    if (q.cnt == last) d.st  = ST_DONE;
                    else               d.cnt = q.cnt + 1'b1;
                end
            end
            ST_DONE: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        fl_cs_n      = (q.st == ST_IDLE) || (q.st == ST_DONE);
        fl_cmd_lat_n = !((q.st == ST_CMD1) || (q.st == ST_CMD2));
        fl_adr_lat_n = !(q.st == ST_ADDR);
        fl_wr_n      = !(((q.st == ST_CMD1) || (q.st == ST_CMD2) ||
                          (q.st == ST_ADDR) || (q.st == ST_DIN)) && !q.ph);
        fl_rd_n      = !((q.st == ST_DOUT) && !q.ph);
        fl_wprot_n   = (q.st != ST_IDLE) &&
                       ((q.op == OP_PROG) || (q.op == OP_ERASE));
        case (q.st)
            ST_CMD1: fl_dout = {8'h00, info.opc1};
            ST_CMD2: fl_dout = {8'h00, info.opc2};
            ST_ADDR: fl_dout = q.cnt[0] ? q.addr[31:16] : q.addr[15:0];
            ST_DIN:  fl_dout = out_half;
            default: fl_dout = '0;
        endcase
    end

    assign host_busy   = (q.st != ST_IDLE);
    assign host_irq    = (q.st == ST_DONE);
    assign id_word     = q.id;
    assign status_byte = q.stat;
    assign buf_addr    = q.cnt[CW-1:1];
    assign buf_we      = q.bwe;
    assign buf_wdata   = q.bwdata;

endmodule

// File: rtl/nseq_checker.sv
module nseq_checker (
    input logic clk,
    input logic rst_n,
    input logic host_busy,
    input logic host_irq,
    input logic buf_we,
    input logic fl_cs_n,
    input logic fl_cmd_lat_n,
    input logic fl_adr_lat_n,
    input logic fl_wr_n,
    input logic fl_rd_n
);

    AST_WR_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_wr_n |=> fl_wr_n); // R4
    AST_RD_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_rd_n |=> fl_rd_n); // R4
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_wr_n && !fl_rd_n)); // R4
    AST_CS_UNDER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_wr_n || !fl_rd_n) |-> !fl_cs_n); // R4
    AST_CMD_LAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_wr_n |=> $stable(fl_cmd_lat_n)); // R4
    AST_ADR_LAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_wr_n |=> $stable(fl_adr_lat_n)); // R4
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |=> (!host_irq && !host_busy)); // R10
    AST_IRQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> host_busy); // R10
    AST_BUF_WRITE_IN_OP: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (host_busy && !fl_cs_n)); // R6

endmodule

bind nand_op_sequencer nseq_checker i_nseq_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_busy    (host_busy),
    .host_irq     (host_irq),
    .buf_we       (buf_we),
    .fl_cs_n      (fl_cs_n),
    .fl_cmd_lat_n (fl_cmd_lat_n),
    .fl_adr_lat_n (fl_adr_lat_n),
    .fl_wr_n      (fl_wr_n),
    .fl_rd_n      (fl_rd_n)
);

// File: tb/test_nand_op_sequencer.sv
`timescale 1ns/1ps
module test_nand_op_sequencer;

    localparam int PW = 8;
    localparam int AW = $clog2(PW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [2:0]    op_sel = 3'd0;
    logic [31:0]   page_addr = '0;
    logic          host_busy, host_irq;
    logic [31:0]   id_word;
    logic [7:0]    status_byte;
    logic [AW-1:0] buf_addr;
    logic [31:0]   buf_rdata;
    logic          buf_we;
    logic [31:0]   buf_wdata;
    logic          fl_cs_n, fl_cmd_lat_n, fl_adr_lat_n, fl_wr_n, fl_rd_n, fl_wprot_n;
    logic [15:0]   fl_dout;
    logic [15:0]   fl_din;
    logic          fl_ready;

    always #5 clk = ~clk;

    nand_op_sequencer #(.PAGE_WORDS(PW)) i_nand_op_sequencer (.*);

    // ---------------- device and buffer model ----------------
    logic [7:0]  cmd_log  [0:63];
    int          cmd_dpos [0:63];
    logic [15:0] addr_log [0:63];
    logic [15:0] data_log [0:255];
    logic [31:0] rdmem    [0:PW-1];
    int ncmd = 0, naddr = 0, ndata = 0, nirq = 0;
    int wide_viol = 0, hold_viol = 0, re_busy_viol = 0, irq_busy_viol = 0, wp_viol = 0;
    logic prev_wr = 1'b1, prev_rd = 1'b1;
    logic cmd_at_fall = 1'b1, adr_at_fall = 1'b1;
    logic [1:0] rd_mode = 2'd0;
    logic [7:0] rd_idx = 8'd0;
    int bsy_wait = 0, bsy_cnt = 0;

    function automatic logic [15:0] pat(input int i);
        return {~8'(i), 8'(i) ^ 8'h5A};
    endfunction

    assign buf_rdata = {16'hB100 + 16'(buf_addr), 16'h7300 + 16'(buf_addr)};

    always_comb begin
        fl_din = 16'h0000;
        if (!fl_rd_n) begin
            case (rd_mode)
                2'd1: fl_din = (rd_idx == 8'd0) ? 16'h2C48 : 16'h00A1;
                2'd2: fl_din = 16'h5AC1;
                2'd3: fl_din = pat(int'(rd_idx));
                default: fl_din = 16'hDEAD;
            endcase
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            fl_ready <= 1'b1;
        end else begin
            prev_wr <= fl_wr_n;
            prev_rd <= fl_rd_n;
            if (!fl_wr_n && prev_wr) begin
                cmd_at_fall <= fl_cmd_lat_n;
                adr_at_fall <= fl_adr_lat_n;
            end
            if (!fl_wr_n && !prev_wr) wide_viol <= wide_viol + 1;
            if (!fl_rd_n && !prev_rd) wide_viol <= wide_viol + 1;
            if (fl_wr_n && !prev_wr && !fl_cs_n) begin
                if (fl_cmd_lat_n != cmd_at_fall || fl_adr_lat_n != adr_at_fall)
                    hold_viol <= hold_viol + 1;
                if (!fl_cmd_lat_n) begin
                    cmd_log[ncmd]  <= fl_dout[7:0];
                    cmd_dpos[ncmd] <= ndata;
                    ncmd <= ncmd + 1;
                    case (fl_dout[7:0])
                        8'h90: begin rd_mode <= 2'd1; rd_idx <= 8'd0; end
                        8'h70: begin rd_mode <= 2'd2; rd_idx <= 8'd0; end
                        8'h30: begin rd_mode <= 2'd3; rd_idx <= 8'd0; end
                        default: ;
                    endcase
                    if (fl_dout[7:0] == 8'h30 || fl_dout[7:0] == 8'h10 ||
                        fl_dout[7:0] == 8'hD0 || fl_dout[7:0] == 8'hFF)
                        bsy_wait <= 3;
                    if ((fl_dout[7:0] == 8'h10 || fl_dout[7:0] == 8'hD0) && !fl_wprot_n)
                        wp_viol <= wp_viol + 1;
                end else if (!fl_adr_lat_n) begin
                    addr_log[naddr] <= fl_dout;
                    naddr <= naddr + 1;
                end else begin
                    data_log[ndata] <= fl_dout;
                    ndata <= ndata + 1;
                    if (!fl_wprot_n) wp_viol <= wp_viol + 1;
                end
            end
            if (fl_rd_n && !prev_rd) rd_idx <= rd_idx + 8'd1;
            if (!fl_rd_n && !fl_ready) re_busy_viol <= re_busy_viol + 1;
            if (bsy_wait != 0) begin
                bsy_wait <= bsy_wait - 1;
                if (bsy_wait == 1) begin
                    fl_ready <= 1'b0;
                    bsy_cnt  <= 6;
                end
            end else if (bsy_cnt != 0) begin
                bsy_cnt <= bsy_cnt - 1;
                if (bsy_cnt == 1) fl_ready <= 1'b1;
            end
            if (host_irq) begin
                nirq <= nirq + 1;
                if (!fl_ready) irq_busy_viol <= irq_busy_viol + 1;
            end
            if (buf_we) rdmem[buf_addr] <= buf_wdata;
        end
    end

    // ---------------- bench bookkeeping ----------------
    int  nchecks = 0, nfail = 0;
    bit  finished = 1'b0;
    int  c0, a0, d0, i0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic snap();
        c0 = ncmd; a0 = naddr; d0 = ndata; i0 = nirq;
    endtask

    task automatic pulse_start(input logic [2:0] op, input logic [31:0] a);
        @(negedge clk);
        start = 1'b1; op_sel = op; page_addr = a;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!host_irq && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " irq seen (watchdog)"}, 32'(host_irq), 32'd1);
        @(negedge clk);
        chk("R10 busy low after irq", 32'(host_busy), 32'd0);
        chk("R10 irq single cycle", 32'(host_irq), 32'd0);
        chk("R12 write protect back low in idle", 32'(fl_wprot_n), 32'd0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_state();
        chk("R1 busy", 32'(host_busy), 32'd0);
        chk("R1 irq", 32'(host_irq), 32'd0);
        chk("R1 pins high", {27'd0, fl_cs_n, fl_cmd_lat_n, fl_adr_lat_n, fl_wr_n, fl_rd_n}, 32'h1F);
        chk("R1 write protect low", 32'(fl_wprot_n), 32'd0);
        chk("R1 id zero", id_word, 32'd0);
    endtask

    task automatic t_read_page();
        snap();
        pulse_start(3'd0, 32'h0003_1A2C);
        wait_done("R6");
        chk("R2 read cmd count", ncmd - c0, 2);
        chk("R2 read opcode 1", cmd_log[c0], 8'h00);
        chk("R2 read opcode 2", cmd_log[c0+1], 8'h30);
        chk("R3 read addr count", naddr - a0, 2);
        chk("R3 read addr low first", addr_log[a0], 16'h1A2C);
        chk("R3 read addr high second", addr_log[a0+1], 16'h0003);
        chk("R5 no read strobe while busy", re_busy_viol, 0);
        for (int w = 0; w < PW; w++)
            chk($sformatf("R6 buffer word %0d", w), rdmem[w], {pat(2*w+1), pat(2*w)});
        chk("R10 one irq for read", nirq - i0, 1);
    endtask

    task automatic t_program();
        snap();
        pulse_start(3'd1, 32'h0002_0040);
        wait_done("R7");
        chk("R2 program opcode 1", cmd_log[c0], 8'h80);
        chk("R2 program opcode 2", cmd_log[c0+1], 8'h10);
        chk("R3 program addr low", addr_log[a0], 16'h0040);
        chk("R3 program addr high", addr_log[a0+1], 16'h0002);
        chk("R7 data writes before 10h", cmd_dpos[c0+1] - d0, 2*PW);
        chk("R7 data write count", ndata - d0, 2*PW);
        for (int w = 0; w < PW; w++) begin
            chk($sformatf("R7 low half word %0d", w), data_log[d0+2*w], 16'h7300 + 16'(w));
            chk($sformatf("R7 high half word %0d", w), data_log[d0+2*w+1], 16'hB100 + 16'(w));
        end
        chk("R12 write protect high during program", wp_viol, 0);
        chk("R8 irq after busy (program)", irq_busy_viol, 0);
    endtask

    task automatic t_erase();
        snap();
        pulse_start(3'd2, 32'h0005_0100);
        wait_done("R8");
        chk("R2 erase opcode 1", cmd_log[c0], 8'h60);
        chk("R2 erase opcode 2", cmd_log[c0+1], 8'hD0);
        chk("R3 erase addr count", naddr - a0, 2);
        chk("R3 erase addr low", addr_log[a0], 16'h0100);
        chk("R3 erase addr high", addr_log[a0+1], 16'h0005);
        chk("R8 erase no data", ndata - d0, 0);
        chk("R8 irq after busy (erase)", irq_busy_viol, 0);
        chk("R12 write protect high for erase", wp_viol, 0);
    endtask

    task automatic t_read_id();
        snap();
        pulse_start(3'd3, 32'hFFFF_FFFF);
        wait_done("R9");
        chk("R2 id opcode", cmd_log[c0], 8'h90);
        chk("R3 id no address", naddr - a0, 0);
        chk("R9 id word packed low first", id_word, 32'h00A1_2C48);
    endtask

    task automatic t_status();
        snap();
        pulse_start(3'd4, 32'h1234_5678);
        wait_done("R9");
        chk("R2 status opcode", cmd_log[c0], 8'h70);
        chk("R3 status no address", naddr - a0, 0);
        chk("R9 status byte", status_byte, 8'hC1);
    endtask

    task automatic t_device_reset();
        snap();
        pulse_start(3'd5, 32'h0);
        wait_done("R8");
        chk("R2 reset opcode", cmd_log[c0], 8'hFF);
        chk("R3 reset no address", naddr - a0, 0);
        chk("R8 irq after busy (reset)", irq_busy_viol, 0);
    endtask

    task automatic t_ignore();
        snap();
        pulse_start(3'd1, 32'h0000_0007);
        repeat (8) @(negedge clk);
        pulse_start(3'd5, 32'h0);
        wait_done("R11");
        chk("R11 only program opcodes", ncmd - c0, 2);
        chk("R11 second opcode still 10h", cmd_log[c0+1], 8'h10);
        chk("R11 single irq", nirq - i0, 1);
        snap();
        pulse_start(3'd6, 32'h0);
        chk("R11 code 6 not busy", 32'(host_busy), 32'd0);
        chk("R11 code 6 no select", 32'(fl_cs_n), 32'd1);
        pulse_start(3'd7, 32'h0);
        repeat (4) @(negedge clk);
        chk("R11 code 7 no commands", ncmd - c0, 0);
        chk("R11 codes 6/7 no irq", nirq - i0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_read_page();
        t_program();
        t_erase();
        t_read_id();
        t_status();
        t_device_reset();
        t_ignore();
        chk("R4 strobe width", wide_viol, 0);
        chk("R4 latch selects held", hold_viol, 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchecks++;
            nfail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
            $finish;
        end
    end

endmodule